// File: doc/BRIEF.md
# Serial Memory Write-Busy Acknowledge Poller

This block is the slave-side decision logic of a two-wire serial memory device. The bus front end decodes bus events and hands them over. These events are start and stop conditions, an abort for a malformed transfer, a received address byte with its strobe, and one completion flag per nonvolatile write target. The block answers with two things. It drives a one-cycle acknowledge enable for each address byte that should be acknowledged. It also drives a busy flag that covers the internal programming cycle.

A programming cycle begins only when a write sequence is properly formed. Such a sequence has an acknowledged address and a completion flag from one of the write targets, and it ends with its stop condition. The cycle lasts a fixed number of clock cycles, set by a parameter. While the cycle runs, the device refuses every command: an address byte that matches is still not acknowledged, whatever its read/write bit holds. A master polls the device by sending start plus address until an acknowledge comes back. An acknowledge means programming is over and the master may go on with the next read or write.

Top module: `wbp_poller`

## Requirements
- R1: The busy flag rises in the cycle right after a stop condition, and only when that stop ends an armed write sequence. A sequence is armed when its acknowledged address was followed by a write-complete flag.
- R2: A completion flag from any of the N_TGT write targets (memory array, potentiometer nonvolatile register, control/status register) arms the sequence in the same way.
- R3: Once started, busy stays high for exactly PROG_CYCLES consecutive clock cycles and then falls.
- R4: While busy is high, except in its final cycle, a matching address byte gets no acknowledge, for either value of the read/write bit (bit 0). A complete write sequence issued during that time neither restarts nor extends the cycle.
- R5: When the device is idle, a matching address byte is acknowledged. The device address is addr_byte[7:1] and must equal DEV_ADDR (default 7'h50). Bit 0 is the read/write bit and is ignored. ack_en is high for the single cycle after the address strobe.
- R6: An address byte whose device address does not match is never acknowledged, whether or not the device is busy.
- R7: None of the following starts the programming cycle: a stop with no completion flag in the sequence, a stop after an abort, or a sequence that a new start replaced before its stop.
- R8: An address byte presented in the final busy cycle is acknowledged, and busy is low in the next cycle.
- R9: A completion flag in a sequence whose address was not acknowledged does not arm it, so the following stop starts nothing.
- R10: After reset, busy and ack_en are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_start | input | 1 | Start condition seen (one-cycle pulse) |
| evt_stop | input | 1 | Stop condition seen (one-cycle pulse) |
| evt_abort | input | 1 | Current transfer is malformed (one-cycle pulse) |
| addr_valid | input | 1 | addr_byte holds a freshly received address byte |
| addr_byte | input | ADDR_W+1 | Address byte: [ADDR_W:1] device address, [0] read/write |
| wr_done | input | N_TGT | One flag per nonvolatile target: a write command finished loading |
| ack_en | output | 1 | Acknowledge the address byte of the previous cycle |
| busy | output | 1 | Internal programming cycle in progress |

## Verification
Directed cases send the matching address with both read/write values, first while idle and then while busy. This shows that the acknowledge depends on the busy window alone and never on bit 0. Write sequences are broken in several ways: no completion flag, an abort, a start that restarts the sequence, and an unmatched address. These separate a proper sequence end from any other stop. A poll timed for the final busy cycle pins down the edge at which the window closes. A long stream of constrained random events is checked every cycle against a bench model of the requirements. It covers overlaps the directed cases miss, such as write attempts and stops arriving inside a busy window.

// File: rtl/wbp_pkg.sv
package wbp_pkg;

   typedef struct packed {
      logic start;
      logic stop;
      logic abort;
   } wbp_evt_t;

   function automatic int wbp_cnt_width(input int n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/wbp_addr_match.sv
module wbp_addr_match #(
   parameter int              ADDR_W   = 7,
   parameter logic [ADDR_W-1:0] DEV_ADDR = 7'h50,
   parameter logic [ADDR_W-1:0] DONTCARE = '0
) (
   input  logic [ADDR_W:0] addr_byte,
   output logic            hit
);

   logic [ADDR_W-1:0] dev_field;

   assign dev_field = addr_byte[ADDR_W:1];

   generate
      if (DONTCARE == '0) begin : g_exact
         assign hit = (dev_field == DEV_ADDR);
      end else begin : g_masked
         assign hit = (((dev_field ^ DEV_ADDR) & ~DONTCARE) == '0);
      end
   endgenerate

endmodule

// File: rtl/wbp_prog_timer.sv
module wbp_prog_timer #(
   parameter int PROG_CYCLES = 500000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic launch,
   output logic busy,
   output logic last
);

   localparam int CW = wbp_pkg::wbp_cnt_width(PROG_CYCLES);
   localparam logic [CW-1:0] CNT_END = CW'(PROG_CYCLES - 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy <= 1'b0;
         cnt  <= '0;
      end else if (busy) begin
         if (cnt == CNT_END) begin
            busy <= 1'b0;
            cnt  <= '0;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end else if (launch) begin
         busy <= 1'b1;
         cnt  <= '0;
      end
   end

   assign last = busy && (cnt == CNT_END);

   AST_TMR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !last) |=> busy); // R3

   AST_TMR_START_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> (cnt == '0)); // R3

   AST_TMR_NO_RELAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !last && launch) |=> (cnt == $past(cnt) + 1'b1)); // R4

endmodule

// File: rtl/wbp_seq_track.sv
module wbp_seq_track #(
   parameter int N_TGT = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  wbp_pkg::wbp_evt_t evt,
   input  logic             addr_ack,
   input  logic [N_TGT-1:0] wr_done,
   output logic             launch
);

   logic sel;
   logic armed;
   logic any_done;

   assign any_done = |wr_done;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel <= 1'b0;
      end else if (evt.start || evt.stop) begin
         sel <= 1'b0;
      end else if (addr_ack) begin
         sel <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed <= 1'b0;
      end else if (evt.start || evt.stop || evt.abort) begin
         armed <= 1'b0;
      end else if (sel && any_done) begin
         armed <= 1'b1;
      end
   end

   assign launch = evt.stop && armed;

   AST_ARM_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(armed) |-> $past(sel)); // R9

   AST_ARM_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(armed) |-> $past(any_done)); // R2

   AST_ABORT_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
      evt.abort |=> !armed); // R7

endmodule

// File: rtl/wbp_poller.sv
module wbp_poller #(
   parameter int                ADDR_W      = 7,
   parameter logic [ADDR_W-1:0] DEV_ADDR    = 7'h50,
   parameter logic [ADDR_W-1:0] DONTCARE    = '0,
   parameter int                N_TGT       = 3,
   parameter int                PROG_CYCLES = 500000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             evt_start,
   input  logic             evt_stop,
   input  logic             evt_abort,
   input  logic             addr_valid,
   input  logic [ADDR_W:0]  addr_byte,
   input  logic [N_TGT-1:0] wr_done,
   output logic             ack_en,
   output logic             busy
);

   generate
      if (PROG_CYCLES < 2) begin : g_bad_prog
         $error("wbp_poller: PROG_CYCLES must be at least 2");
      end
      if (N_TGT < 1) begin : g_bad_tgt
         $error("wbp_poller: N_TGT must be at least 1");
      end
      if (ADDR_W < 1) begin : g_bad_addr
         $error("wbp_poller: ADDR_W must be at least 1");
      end
   endgenerate

   wbp_pkg::wbp_evt_t evt;
   logic hit;
   logic tmr_last;
   logic launch;
   logic locked;
   logic ack_now;

   assign evt.start = evt_start;
   assign evt.stop  = evt_stop;
   assign evt.abort = evt_abort;

   wbp_addr_match #(
      .ADDR_W  (ADDR_W),
      .DEV_ADDR(DEV_ADDR),
      .DONTCARE(DONTCARE)
   ) u_match (
      .addr_byte(addr_byte),
      .hit      (hit)
   );

   wbp_prog_timer #(
      .PROG_CYCLES(PROG_CYCLES)
   ) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .launch(launch),
      .busy  (busy),
      .last  (tmr_last)
   );

   wbp_seq_track #(
      .N_TGT(N_TGT)
   ) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .evt     (evt),
      .addr_ack(ack_now),
      .wr_done (wr_done),
      .launch  (launch)
   );

   assign locked  = busy && !tmr_last;
   assign ack_now = addr_valid && hit && !locked;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ack_en <= 1'b0;
      end else begin
         ack_en <= ack_now;
      end
   end

   AST_BUSY_NACK: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_valid && busy && !tmr_last) |=> !ack_en); // R4

   AST_MISMATCH_NACK: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_valid && !hit) |=> !ack_en); // R6

   AST_BUSY_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(evt_stop)); // R1

   AST_TERMINAL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_valid && hit && tmr_last) |=> (ack_en && !busy)); // R8

   AST_IDLE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_valid && hit && !busy) |=> ack_en); // R5

endmodule

// File: tb/tb_wbp_poller.sv
module tb_wbp_poller;

   localparam int PROG = 40;
   localparam logic [6:0] DEV = 7'h50;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       evt_start, evt_stop, evt_abort, addr_valid;
   logic [7:0] addr_byte;
   logic [2:0] wr_done;
   logic       ack_en, busy;

   int checks = 0;
   int fails  = 0;

   int m_left  = 0;
   bit m_sel   = 1'b0;
   bit m_armed = 1'b0;

   always #5 clk = ~clk;

   wbp_poller #(
      .ADDR_W(7), .DEV_ADDR(DEV), .DONTCARE(7'h00),
      .N_TGT(3), .PROG_CYCLES(PROG)
   ) dut (
      .clk(clk), .rst_n(rst_n), .evt_start(evt_start), .evt_stop(evt_stop),
      .evt_abort(evt_abort), .addr_valid(addr_valid), .addr_byte(addr_byte),
      .wr_done(wr_done), .ack_en(ack_en), .busy(busy)
   );

   function automatic bit dev_match(input logic [7:0] b);
      return b[7:1] == DEV;
   endfunction

   task automatic check(input logic act, input bit exp, input string tag, input string what);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%0b expected=%0b t=%0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic cyc(input bit st, input bit sp, input bit er, input bit av,
                      input logic [7:0] ab, input logic [2:0] dn, input string tag);
      bit e_ack;
      int n_left;
      bit n_sel, n_armed;
      evt_start = st; evt_stop = sp; evt_abort = er;
      addr_valid = av; addr_byte = ab; wr_done = dn;
      e_ack   = av && dev_match(ab) && !(m_left > 1);
      n_left  = (m_left > 0) ? m_left - 1 : 0;
      if (sp && m_armed && m_left == 0) n_left = PROG;
      n_sel   = (st || sp) ? 1'b0 : (e_ack ? 1'b1 : m_sel);
      n_armed = (st || sp || er) ? 1'b0 : ((m_sel && (dn != 3'b000)) ? 1'b1 : m_armed);
      @(posedge clk);
      #1;
      check(busy, n_left > 0, tag, "busy");
      check(ack_en, e_ack, tag, "ack_en");
      m_left = n_left; m_sel = n_sel; m_armed = n_armed;
      evt_start = 0; evt_stop = 0; evt_abort = 0; addr_valid = 0;
      addr_byte = 8'h00; wr_done = 3'b000;
      @(negedge clk);
   endtask

   task automatic idle(input string tag);
      cyc(0, 0, 0, 0, 8'h00, 3'b000, tag);
   endtask

   task automatic write_seq(input logic [7:0] ab, input logic [2:0] dn, input string tag);
      cyc(1, 0, 0, 0, 8'h00, 3'b000, tag);
      cyc(0, 0, 0, 1, ab, 3'b000, tag);
      cyc(0, 0, 0, 0, 8'h00, dn, tag);
      cyc(0, 1, 0, 0, 8'h00, 3'b000, tag);
   endtask

   task automatic drain(input string tag);
      while (m_left > 0) idle(tag);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL R3 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      rst_n = 0; evt_start = 0; evt_stop = 0; evt_abort = 0;
      addr_valid = 0; addr_byte = 0; wr_done = 0;
      repeat (3) @(negedge clk);
      check(busy, 1'b0, "R10", "busy in reset");
      check(ack_en, 1'b0, "R10", "ack in reset");
      rst_n = 1;
      @(negedge clk);
      check(busy, 1'b0, "R10", "busy after reset");
      check(ack_en, 1'b0, "R10", "ack after reset");

      // R5: idle polls with either read/write bit
      cyc(1, 0, 0, 0, 8'h00, 3'b000, "R5");
      cyc(0, 0, 0, 1, 8'hA0, 3'b000, "R5");
      idle("R5");
      cyc(0, 0, 0, 1, 8'hA1, 3'b000, "R5");
      cyc(0, 1, 0, 0, 8'h00, 3'b000, "R5");
      // R6: mismatched addresses while idle
      cyc(0, 0, 0, 1, 8'hB0, 3'b000, "R6");
      cyc(0, 0, 0, 1, 8'h21, 3'b000, "R6");

      // R1 and R3: full write, polls while busy, terminal-cycle poll
      write_seq(8'hA0, 3'b001, "R1");
      check(busy, 1'b1, "R1", "busy after stop");
      cyc(0, 0, 0, 1, 8'hA1, 3'b000, "R4");
      cyc(0, 0, 0, 1, 8'hA0, 3'b000, "R4");
      cyc(0, 0, 0, 1, 8'hB1, 3'b000, "R6");
      while (m_left > 1) idle("R3");
      cyc(0, 0, 0, 1, 8'hA1, 3'b000, "R8");
      check(busy, 1'b0, "R8", "busy after terminal");
      idle("R8");

      // R2: the other write targets
      write_seq(8'hA0, 3'b010, "R2");
      check(busy, 1'b1, "R2", "busy target1");
      drain("R3");
      write_seq(8'hA0, 3'b100, "R2");
      check(busy, 1'b1, "R2", "busy target2");
      // R4: write sequence issued during busy is refused
      cyc(1, 0, 0, 0, 8'h00, 3'b000, "R4");
      cyc(0, 0, 0, 1, 8'hA0, 3'b000, "R4");
      cyc(0, 0, 0, 0, 8'h00, 3'b001, "R4");
      cyc(0, 1, 0, 0, 8'h00, 3'b000, "R4");
      drain("R4");
      idle("R4");
      check(busy, 1'b0, "R4", "no restart");

      // R7: broken sequences
      cyc(1, 0, 0, 0, 8'h00, 3'b000, "R7");
      cyc(0, 0, 0, 1, 8'hA0, 3'b000, "R7");
      cyc(0, 1, 0, 0, 8'h00, 3'b000, "R7");
      idle("R7");
      cyc(1, 0, 0, 0, 8'h00, 3'b000, "R7");
      cyc(0, 0, 0, 1, 8'hA0, 3'b000, "R7");
      cyc(0, 0, 0, 0, 8'h00, 3'b001, "R7");
      cyc(0, 0, 1, 0, 8'h00, 3'b000, "R7");
      cyc(0, 1, 0, 0, 8'h00, 3'b000, "R7");
      idle("R7");
      cyc(1, 0, 0, 0, 8'h00, 3'b000, "R7");
      cyc(0, 0, 0, 1, 8'hA0, 3'b000, "R7");
      cyc(0, 0, 0, 0, 8'h00, 3'b001, "R7");
      cyc(1, 0, 0, 0, 8'h00, 3'b000, "R7");
      cyc(0, 1, 0, 0, 8'h00, 3'b000, "R7");
      idle("R7");
      check(busy, 1'b0, "R7", "no cycle from broken sequences");

      // R9: completion after unacknowledged address
      write_seq(8'hB0, 3'b001, "R9");
      idle("R9");
      check(busy, 1'b0, "R9", "no cycle after nack");

      // constrained random mix
      for (int i = 0; i < 4000; i++) begin
         int sel = $urandom_range(0, 19);
         logic [7:0] ab = ($urandom_range(0, 1) == 1) ? {DEV, 1'($urandom_range(0, 1))}
                                                      : 8'($urandom);
         if (sel == 0)      cyc(1, 0, 0, 0, 8'h00, 3'b000, "R7");
         else if (sel == 1) cyc(0, 1, 0, 0, 8'h00, 3'b000, "R1");
         else if (sel == 2) cyc(0, 0, 1, 0, 8'h00, 3'b000, "R7");
         else if (sel < 6)  cyc(0, 0, 0, 1, ab, 3'b000, "R5");
         else if (sel < 8)  cyc(0, 0, 0, 0, 8'h00, 3'(1 << $urandom_range(0, 2)), "R2");
         else if (sel == 8) write_seq(ab, 3'(1 << $urandom_range(0, 2)), "R3");
         else               idle("R3");
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule